// File: doc/BRIEF.md
# Multiframe Phase Counter

This block keeps the local multiframe phase for one end of a deterministic-latency serial converter link. It runs in the device clock domain and counts octet positions through one multiframe. The multiframe holds `frame_len × frames_per_mf` octets. The block produces a marker on the first octet of each multiframe and a marker on the first octet of each frame.

Every device in the system receives a shared alignment reference that arrives asynchronously. The block passes it through a synchronizer and detects its rising edge. That edge forces the count back to zero, so all devices that see the same reference agree on the multiframe boundary to within one device clock.

After alignment, software-free control is possible through `align_en`. Clearing it makes the counter ignore later reference edges, so a periodic reference cannot disturb a running link. When an accepted edge lands at a nonzero position, a sticky flag is raised and the position at which the edge landed is recorded, which helps with debugging.

The block has no data stream. All pins are plain control and status.

Top module: `mframe_clk_gen`

## Requirements
- R1: While `rst_n` is low, `mf_count` is 0, `mf_start` and `frame_start` are 0, `phase_err` is 0 and `phase_err_at` is 0. On the first clock after reset is released, the block loads its configuration and begins counting from 0.
- R2: `mf_count` advances by one each clock, from 0 up to (F×K)−1, and then returns to 0. F is the latched `frame_len` and K is the latched `frames_per_mf`.
- R3: `mf_start` is 1 exactly on the cycles where the block is counting and `mf_count` is 0.
- R4: `frame_start` is 1 on every F-th count, starting at `mf_count` 0. Its phase restarts at every multiframe wrap.
- R5: Suppose `align_in` is first sampled high at clock edge n after having been low, and `align_en` is 1. Then at edge n+2 the count is forced to 0, and `mf_count` reads 0 after that edge. The delay comes from a two-flop synchronizer followed by edge detection.
- R6: Holding `align_in` high does not re-trigger the counter. Only a low-to-high transition counts as an edge.
- R7: While `align_en` is 0, a reference edge has no effect: the count keeps advancing and the error outputs are unchanged.
- R8: A change of `frame_len` or `frames_per_mf` in mid-count takes effect only at the next wrap or the next accepted reference edge. Until then the old period continues.
- R9: An accepted edge that lands when `mf_count` is nonzero sets `phase_err`. The flag stays set until reset. The edge also stores that nonzero count in `phase_err_at`. An edge landing at count 0 changes neither output.
- R10: A `frame_len` or `frames_per_mf` value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| align_in | input | 1 | Shared alignment reference, asynchronous |
| align_en | input | 1 | 1 = reference edges re-phase the counter |
| frame_len | input | FW (5) | Octets per frame (F) |
| frames_per_mf | input | KW (6) | Frames per multiframe (K) |
| mf_count | output | FW+KW (11) | Current octet position in the multiframe |
| mf_start | output | 1 | First octet of a multiframe |
| frame_start | output | 1 | First octet of a frame |
| phase_err | output | 1 | Sticky: an accepted edge landed off the boundary |
| phase_err_at | output | FW+KW (11) | Count at which the last misaligned edge landed |

## Verification
The assertions assume only that `align_in` may change at any time relative to the clock. Each accepted edge is a single synchronized pulse, and the configuration pins may change at any time. The properties therefore track latched configuration rather than pin values. The stimulus changes every input shortly after a rising clock edge and holds the reference high for several cycles. It places edges both at the multiframe boundary and away from it, and it only changes the configuration pins in mid-count or under reset, which are the two cases the requirements define.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  typedef enum logic {
    MF_IDLE = 1'b0,
    MF_RUN  = 1'b1
  } mf_state_e;
endpackage

// File: rtl/mfc_edge_sync.sv
module mfc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise_o = chain[STAGES-1] & ~chain[STAGES];

  // R6
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/mfc_cfg_latch.sv
module mfc_cfg_latch #(
  parameter int FW = 5,
  parameter int KW = 6,
  localparam int CW = FW + KW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] f_in,
  input  logic [KW-1:0] k_in,
  output logic [FW-1:0] f_q,
  output logic [CW-1:0] last_q
);
  logic [FW-1:0] f_eff;
  logic [KW-1:0] k_eff;
  logic [CW-1:0] span;

  assign f_eff = (f_in == '0) ? FW'(1) : f_in;
  assign k_eff = (k_in == '0) ? KW'(1) : k_in;
  assign span  = CW'(f_eff) * CW'(k_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q    <= FW'(1);
      last_q <= '0;
    end else if (load) begin
      f_q    <= f_eff;
      last_q <= span - CW'(1);
    end
  end

  // R10
  zero_len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && f_in == '0) |=> (f_q == FW'(1)));
  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(last_q) && $stable(f_q));
endmodule

// File: rtl/mfc_counter.sv
module mfc_counter
  import mfc_pkg::*;
#(
  parameter int FW = 5,
  parameter int KW = 6,
  localparam int CW = FW + KW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          align_en,
  input  logic [FW-1:0] f_q,
  input  logic [CW-1:0] last_q,
  output logic          load,
  output logic          running,
  output logic [CW-1:0] count,
  output logic          frame_zero,
  output logic          err_flag,
  output logic [CW-1:0] err_at
);
  mf_state_e     state;
  logic [FW-1:0] fpos;
  logic          accept;
  logic          wrap;

  assign running    = (state == MF_RUN);
  assign accept     = running && rise && align_en;
  assign wrap       = running && !accept && (count == last_q);
  assign load       = !running || accept || wrap;
  assign frame_zero = (fpos == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= MF_IDLE;
      count <= '0;
      fpos  <= '0;
    end else if (!running || accept || wrap) begin
      state <= MF_RUN;
      count <= '0;
      fpos  <= '0;
    end else begin
      count <= count + CW'(1);
      fpos  <= (fpos == f_q - FW'(1)) ? '0 : fpos + FW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      err_at   <= '0;
    end else if (accept && count != '0) begin
      err_flag <= 1'b1;
      err_at   <= count;
    end
  end

  // R2
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> count <= last_q);
  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> count == '0);
  // R5
  rephase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> count == '0);
  // R7
  ignore_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && rise && !align_en && count != last_q) |=> count == $past(count) + CW'(1));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
endmodule

// File: rtl/mframe_clk_gen.sv
module mframe_clk_gen #(
  parameter int FW = 5,
  parameter int KW = 6,
  parameter int SYNC_STAGES = 2,
  localparam int CW = FW + KW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          align_in,
  input  logic          align_en,
  input  logic [FW-1:0] frame_len,
  input  logic [KW-1:0] frames_per_mf,
  output logic [CW-1:0] mf_count,
  output logic          mf_start,
  output logic          frame_start,
  output logic          phase_err,
  output logic [CW-1:0] phase_err_at
);
  logic          rise;
  logic          load;
  logic          running;
  logic          frame_zero;
  logic [FW-1:0] f_q;
  logic [CW-1:0] last_q;

  mfc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(align_in), .rise_o(rise)
  );

  mfc_cfg_latch #(.FW(FW), .KW(KW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load), .f_in(frame_len),
    .k_in(frames_per_mf), .f_q(f_q), .last_q(last_q)
  );

  mfc_counter #(.FW(FW), .KW(KW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .rise(rise), .align_en(align_en),
    .f_q(f_q), .last_q(last_q), .load(load), .running(running),
    .count(mf_count), .frame_zero(frame_zero),
    .err_flag(phase_err), .err_at(phase_err_at)
  );

  assign mf_start    = running && (mf_count == '0);
  assign frame_start = running && frame_zero;

  // R3 R4
  mf_implies_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mf_start |-> frame_start);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !mf_start && !frame_start && !phase_err);
endmodule

// File: tb/mframe_clk_gen_bench.sv
module mframe_clk_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 5;
  localparam int KW = 6;
  localparam int CW = FW + KW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          align_in = 1'b0;
  logic          align_en = 1'b1;
  logic [FW-1:0] frame_len = 5'd4;
  logic [KW-1:0] frames_per_mf = 6'd4;
  logic [CW-1:0] mf_count;
  logic          mf_start, frame_start, phase_err;
  logic [CW-1:0] phase_err_at;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mframe_clk_gen #(.FW(FW), .KW(KW)) u_mframe_clk_gen (
    .clk(clk), .rst_n(rst_n), .align_in(align_in), .align_en(align_en),
    .frame_len(frame_len), .frames_per_mf(frames_per_mf),
    .mf_count(mf_count), .mf_start(mf_start), .frame_start(frame_start),
    .phase_err(phase_err), .phase_err_at(phase_err_at)
  );

  // behavioural reference
  int mc, mfp, mF, mK, mP, merrv;
  bit mrun, merr, s1, s2, s3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc = 0; mfp = 0; mF = 1; mK = 1; mP = 1; merrv = 0;
      mrun = 0; merr = 0; s1 = 0; s2 = 0; s3 = 0;
    end else begin
      bit edge_seen;
      edge_seen = s2 && !s3;
      s3 = s2; s2 = s1; s1 = align_in;
      if (!mrun || (edge_seen && align_en) || mc == mP - 1) begin
        if (mrun && edge_seen && align_en && mc != 0) begin
          merr = 1; merrv = mc;
        end
        mF = (frame_len == 0) ? 1 : int'(frame_len);
        mK = (frames_per_mf == 0) ? 1 : int'(frames_per_mf);
        mP = mF * mK;
        mrun = 1; mc = 0; mfp = 0;
      end else begin
        mc = mc + 1;
        mfp = (mfp == mF - 1) ? 0 : mfp + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(int'(mf_count) == mc, "R2 count", int'(mf_count), mc);
      check(mf_start == (mrun && mc == 0), "R3 mf_start", mf_start, mrun && mc == 0);
      check(frame_start == (mrun && mfp == 0), "R4 frame_start", frame_start, mrun && mfp == 0);
      check(phase_err == merr, "R9 flag", phase_err, merr);
      check(int'(phase_err_at) == merrv, "R9 value", int'(phase_err_at), merrv);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_count(input int v);
    for (int i = 0; i < 200 && int'(mf_count) != v; i++) step(1);
  endtask

  initial begin
    int prev, v, c0;
    step(3);
    check(mf_count == 0 && !mf_start && !frame_start && !phase_err && phase_err_at == 0,
          "R1 reset state", int'(mf_count), 0);
    rst_n = 1'b1;
    step(40);

    // R8: change mid-count; old period of 16 finishes first
    wait_count(5);
    frame_len = 5'd3; frames_per_mf = 6'd5;
    prev = int'(mf_count);
    for (int i = 0; i < 40 && mf_count != 0; i++) begin prev = int'(mf_count); step(1); end
    check(prev == 15, "R8 old period kept", prev, 15);
    step(1);
    for (int i = 0; i < 40 && mf_count != 0; i++) begin prev = int'(mf_count); step(1); end
    check(prev == 14, "R8 new period used", prev, 14);

    // R9: edge landing on boundary, no error
    wait_count(13);
    align_in = 1'b1;
    step(3);
    check(mf_count == 0, "R5 aligned edge", int'(mf_count), 0);
    check(!phase_err, "R9 no error at zero", phase_err, 0);
    step(5);
    check(mf_count == 5, "R6 held level", int'(mf_count), 5);
    align_in = 1'b0;
    step(4);

    // R5 / R9: misaligned edge
    wait_count(6);
    align_in = 1'b1;
    step(2);
    v = int'(mf_count);
    step(1);
    check(mf_count == 0, "R5 rephase latency", int'(mf_count), 0);
    check(phase_err && int'(phase_err_at) == v, "R9 capture", int'(phase_err_at), v);
    align_in = 1'b0;
    step(3);

    // R7: disabled edges ignored
    align_en = 1'b0;
    c0 = int'(mf_count);
    align_in = 1'b1;
    step(3);
    check(int'(mf_count) == (c0 + 3) % 15, "R7 count undisturbed", int'(mf_count), (c0 + 3) % 15);
    align_in = 1'b0;
    step(2);
    check(int'(phase_err_at) == v, "R7 error unchanged", int'(phase_err_at), v);
    align_en = 1'b1;

    // R10: zero configuration behaves as one
    frame_len = '0; frames_per_mf = '0;
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(3);
    check(mf_count == 0 && mf_start && frame_start, "R10 zero clamp", int'(mf_count), 0);
    step(10);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1'b1;
      vectors++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule